// File: doc/BRIEF.md
# Video Timing Generator with Early Fetch Trigger

This block produces the raster timing for a display interface. A single frame counter advances once per pixel clock and wraps at a programmable frame length. A second counter, the line position, runs alongside it and wraps at the programmed line period. Horizontal sync and the horizontal active window come from the line position. Vertical sync and the vertical active window are compared directly against the frame counter. All vertical quantities are therefore absolute pixel-clock counts, not line numbers.

Besides hsync, vsync and data-enable, the block raises a one-clock fetch trigger at a programmable point of the frame. An upstream pixel source uses this trigger to start prefilling before active video. Software places the trigger in blanking, no more than 25 lines ahead of the first active line. During active video the block forwards the upstream pixel. When the upstream source has no pixel ready, the block substitutes a programmable fill colour and sets a sticky underrun flag.

Registers are written through an enable/address/data port. Timing and colour writes go to a shadow copy, which is transferred to the working copy only when the frame wraps. A frame is therefore never timed with a mix of old and new values.

Top module: `video_timing_gen`

## Requirements
- R1: While `rst` is high, every output is driven low and both counters are cleared. The working and shadow settings take the parameter defaults: line period 10, hsync width 2, frame 60 clocks, vsync width 10, horizontal window 3..8, vertical window 20..49, fetch disabled at count 0, and fill colour 0.
- R2: The frame counter steps by one per clock and returns to 0 after reaching frame length minus 1. The line position steps alongside it, returns to 0 after line period minus 1, and is also forced to 0 whenever the frame counter wraps.
- R3: `hsync_o` is high for line positions below the hsync width. Address 0 holds the line period in bits 31:16 and the hsync width in bits 15:0.
- R4: `vsync_o` is high for frame counts below the vsync width. Address 2 holds the vsync width and address 1 holds the frame length, both in pixel clocks.
- R5: `de_o` is high only when two conditions hold together. The line position must lie within the horizontal window, inclusive: address 3 holds the end in bits 31:16 and the start in bits 15:0. The frame count must lie within the vertical window, inclusive: address 4 holds the start and address 5 holds the end.
- R6: `fetch_start_o` pulses for one clock when the fetch enable is set and the frame count equals the fetch position. The enable is bit 31 of address 6 and the position is held at address 7.
- R7: With data-enable true, `pixel_o` carries `pix_data_i` when `pix_valid_i` is high. When `pix_valid_i` is low, it carries the fill colour held in the low bits of address 8. Outside the active window `pixel_o` is 0.
- R8: `underflow_o` is set by any active-window position without a valid pixel, and stays set until a write to address 9 with bit 0 high. If a new underrun and the clearing write arrive in the same clock, the flag stays set.
- R9: Writes to addresses 0 through 8 take effect at the first frame wrap after the write clock. A write made in the very clock of a wrap waits for the following wrap.
- R10: All outputs are registered. The outputs for a counter position, together with the pixel sample presented in that same clock, appear one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| pix_valid_i | input | 1 | Upstream pixel present |
| pix_data_i | input | PIX_W | Upstream pixel value |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Data enable |
| fetch_start_o | output | 1 | One-clock prefill trigger |
| pixel_o | output | PIX_W | Output pixel |
| underflow_o | output | 1 | Sticky underrun flag |

## Verification
Every output is due exactly one clock after the counter position and pixel sample that produced it. Register writes act on the counters only after the next wrap, so a new setting first shows in the outputs one clock after that wrap. The bench model advances on the same edge as the design and derives the expected outputs for each edge from its own state before stepping. The bench samples on the falling edge, so each comparison lands half a clock after the edge that made the value. Writes are issued mid-frame and in bursts near the wrap. This exposes any setting that leaks into the current frame, and the per-cycle comparison catches the leak on the first cycle it occurs.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int CNT_W = 32;
  localparam int POS_W = 16;

  typedef enum logic [3:0] {
    A_HCTL   = 4'd0,
    A_FRAME  = 4'd1,
    A_VSW    = 4'd2,
    A_HWIN   = 4'd3,
    A_VSTART = 4'd4,
    A_VEND   = 4'd5,
    A_FCFG   = 4'd6,
    A_FPOS   = 4'd7,
    A_FILL   = 4'd8,
    A_STAT   = 4'd9
  } reg_addr_e;

  typedef struct packed {
    logic [POS_W-1:0] line_per;
    logic [POS_W-1:0] hs_w;
    logic [CNT_W-1:0] frame_len;
    logic [CNT_W-1:0] vs_w;
    logic [POS_W-1:0] h_end;
    logic [POS_W-1:0] h_start;
    logic [CNT_W-1:0] v_start;
    logic [CNT_W-1:0] v_end;
    logic             fetch_en;
    logic [CNT_W-1:0] fetch_pos;
  } timing_cfg_t;
endpackage

// File: rtl/vtg_cfg_regs.sv
module vtg_cfg_regs
  import vtg_pkg::*;
#(
  parameter int                PIX_W = 24,
  parameter timing_cfg_t       RST_CFG = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [3:0]         addr,
  input  logic [CNT_W-1:0]   wdata,
  input  logic               wrap_i,
  input  logic               underrun_i,
  output timing_cfg_t        act_cfg,
  output logic [PIX_W-1:0]   act_fill,
  output logic               sticky_o
);
  timing_cfg_t      sh_cfg;
  logic [PIX_W-1:0] sh_fill;
  logic             clr_req;

  assign clr_req = we && (addr == A_STAT) && wdata[0];

  // shadow copy, loaded by the write port
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_cfg  <= RST_CFG;
      sh_fill <= '0;
    end else if (we) begin
      case (addr)
        A_HCTL:   {sh_cfg.line_per, sh_cfg.hs_w} <= wdata;
        A_FRAME:  sh_cfg.frame_len <= wdata;
        A_VSW:    sh_cfg.vs_w <= wdata;
        A_HWIN:   {sh_cfg.h_end, sh_cfg.h_start} <= wdata;
        A_VSTART: sh_cfg.v_start <= wdata;
        A_VEND:   sh_cfg.v_end <= wdata;
        A_FCFG:   sh_cfg.fetch_en <= wdata[CNT_W-1];
        A_FPOS:   sh_cfg.fetch_pos <= wdata;
        A_FILL:   sh_fill <= wdata[PIX_W-1:0];
        default:  ;
      endcase
    end
  end

  // working copy, moves only on the frame wrap
  always_ff @(posedge clk) begin
    if (rst) begin
      act_cfg  <= RST_CFG;
      act_fill <= '0;
    end else if (wrap_i) begin
      act_cfg  <= sh_cfg;
      act_fill <= sh_fill;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             sticky_o <= 1'b0;
    else if (underrun_i) sticky_o <= 1'b1;
    else if (clr_req)    sticky_o <= 1'b0;
  end

  // R8: the flag only drops through a clearing write
  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (sticky_o && !clr_req) |=> sticky_o);

  // R8: an underrun always leaves the flag set
  p_sticky_set_r8: assert property (@(posedge clk) disable iff (rst)
    underrun_i |=> sticky_o);

  // R9: without a wrap the working settings hold
  p_hold_no_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    !wrap_i |=> $stable(act_cfg));
endmodule

// File: rtl/vtg_counters.sv
module vtg_counters
  import vtg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] line_per,
  input  logic [CNT_W-1:0] frame_len,
  output logic [CNT_W-1:0] fcnt,
  output logic [POS_W-1:0] hpos,
  output logic             wrap_o
);
  logic line_end;

  assign wrap_o   = (fcnt == frame_len - CNT_W'(1));
  assign line_end = (hpos == line_per - POS_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt <= '0;
      hpos <= '0;
    end else if (wrap_o) begin
      fcnt <= '0;
      hpos <= '0;
    end else begin
      fcnt <= fcnt + CNT_W'(1);
      hpos <= line_end ? '0 : hpos + POS_W'(1);
    end
  end

  // R2: both counters restart together
  p_wrap_together_r2: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (fcnt == '0 && hpos == '0));

  // R2: ordinary step of the frame counter
  p_frame_step_r2: assert property (@(posedge clk) disable iff (rst)
    !wrap_o |=> fcnt == $past(fcnt) + CNT_W'(1));
endmodule

// File: rtl/vtg_out_stage.sv
module vtg_out_stage
  import vtg_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] fcnt,
  input  logic [POS_W-1:0] hpos,
  input  logic [POS_W-1:0] hs_w,
  input  logic [CNT_W-1:0] vs_w,
  input  logic [POS_W-1:0] h_start,
  input  logic [POS_W-1:0] h_end,
  input  logic [CNT_W-1:0] v_start,
  input  logic [CNT_W-1:0] v_end,
  input  logic             fetch_en,
  input  logic [CNT_W-1:0] fetch_pos,
  input  logic [PIX_W-1:0] fill,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_data_i,
  output logic             underrun_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic             fetch_o,
  output logic [PIX_W-1:0] pixel_o
);
  logic in_h, in_v, de_n;

  assign in_h       = (hpos >= h_start) && (hpos <= h_end);
  assign in_v       = (fcnt >= v_start) && (fcnt <= v_end);
  assign de_n       = in_h && in_v;
  assign underrun_o = de_n && !pix_valid_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      de_o    <= 1'b0;
      fetch_o <= 1'b0;
      pixel_o <= '0;
    end else begin
      hsync_o <= (hpos < hs_w);
      vsync_o <= (fcnt < vs_w);
      de_o    <= de_n;
      fetch_o <= fetch_en && (fcnt == fetch_pos);
      if (!de_n)            pixel_o <= '0;
      else if (pix_valid_i) pixel_o <= pix_data_i;
      else                  pixel_o <= fill;
    end
  end

  // R7: blanking carries a zero pixel
  p_blank_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !de_o |-> pixel_o == '0);

  // R5: data-enable follows a position inside both windows
  p_de_window_r5: assert property (@(posedge clk) disable iff (rst)
    (hpos < h_start || fcnt > v_end) |=> !de_o);

  // R6: no fetch trigger while disabled
  p_fetch_gated_r6: assert property (@(posedge clk) disable iff (rst)
    !fetch_en |=> !fetch_o);
endmodule

// File: rtl/video_timing_gen.sv
module video_timing_gen
  import vtg_pkg::*;
#(
  parameter int PIX_W         = 24,
  parameter int RST_LINE_PER  = 10,
  parameter int RST_HS_W      = 2,
  parameter int RST_FRAME_LEN = 60,
  parameter int RST_VS_W      = 10,
  parameter int RST_H_START   = 3,
  parameter int RST_H_END     = 8,
  parameter int RST_V_START   = 20,
  parameter int RST_V_END     = 49
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_data_i,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic             fetch_start_o,
  output logic [PIX_W-1:0] pixel_o,
  output logic             underflow_o
);
  localparam timing_cfg_t RST_CFG = '{
    line_per:  POS_W'(RST_LINE_PER),
    hs_w:      POS_W'(RST_HS_W),
    frame_len: CNT_W'(RST_FRAME_LEN),
    vs_w:      CNT_W'(RST_VS_W),
    h_end:     POS_W'(RST_H_END),
    h_start:   POS_W'(RST_H_START),
    v_start:   CNT_W'(RST_V_START),
    v_end:     CNT_W'(RST_V_END),
    fetch_en:  1'b0,
    fetch_pos: '0
  };

  timing_cfg_t      act_cfg;
  logic [PIX_W-1:0] act_fill;
  logic [CNT_W-1:0] fcnt;
  logic [POS_W-1:0] hpos;
  logic             wrap, underrun;

  vtg_cfg_regs #(.PIX_W(PIX_W), .RST_CFG(RST_CFG)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .wrap_i(wrap), .underrun_i(underrun),
    .act_cfg(act_cfg), .act_fill(act_fill), .sticky_o(underflow_o)
  );

  vtg_counters u_cnt (
    .clk(clk), .rst(rst), .line_per(act_cfg.line_per),
    .frame_len(act_cfg.frame_len), .fcnt(fcnt), .hpos(hpos), .wrap_o(wrap)
  );

  vtg_out_stage #(.PIX_W(PIX_W)) u_out (
    .clk(clk), .rst(rst), .fcnt(fcnt), .hpos(hpos),
    .hs_w(act_cfg.hs_w), .vs_w(act_cfg.vs_w),
    .h_start(act_cfg.h_start), .h_end(act_cfg.h_end),
    .v_start(act_cfg.v_start), .v_end(act_cfg.v_end),
    .fetch_en(act_cfg.fetch_en), .fetch_pos(act_cfg.fetch_pos),
    .fill(act_fill), .pix_valid_i(pix_valid_i), .pix_data_i(pix_data_i),
    .underrun_o(underrun), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .fetch_o(fetch_start_o), .pixel_o(pixel_o)
  );

  // R9: settings change only in the clock the counters restart
  p_cfg_at_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (fcnt != '0) |-> $stable(act_cfg));

  // R2: line position stays below a nonzero line period
  p_hpos_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (act_cfg.line_per != '0) |-> hpos < act_cfg.line_per);
endmodule

// File: tb/test_video_timing_gen.sv
module test_video_timing_gen;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          pix_valid_i = 1'b1;
  logic [PW-1:0] pix_data_i = '0;
  logic          hsync_o, vsync_o, de_o, fetch_start_o, underflow_o;
  logic [PW-1:0] pixel_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit drop_mode = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  video_timing_gen #(
    .PIX_W(PW), .RST_LINE_PER(10), .RST_HS_W(2), .RST_FRAME_LEN(60),
    .RST_VS_W(10), .RST_H_START(3), .RST_H_END(8),
    .RST_V_START(20), .RST_V_END(49)
  ) i_video_timing_gen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_valid_i(pix_valid_i), .pix_data_i(pix_data_i),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .fetch_start_o(fetch_start_o), .pixel_o(pixel_o), .underflow_o(underflow_o)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] sh [0:8];
  logic [31:0] ac [0:8];
  int unsigned m_f, m_h;
  logic e_hs, e_vs, e_de, e_fe, e_st;
  logic [PW-1:0] e_px;

  task automatic load_defaults();
    sh[0] = {16'd10, 16'd2}; sh[1] = 60; sh[2] = 10;
    sh[3] = {16'd8, 16'd3};  sh[4] = 20; sh[5] = 49;
    sh[6] = 0; sh[7] = 0; sh[8] = 0;
    for (int i = 0; i < 9; i++) ac[i] = sh[i];
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      load_defaults();
      m_f = 0; m_h = 0;
      e_hs = 0; e_vs = 0; e_de = 0; e_fe = 0; e_st = 0; e_px = '0;
    end else begin
      int unsigned lp, fl;
      logic de;
      lp = ac[0][31:16];
      fl = ac[1];
      de = (m_h >= ac[3][15:0]) && (m_h <= ac[3][31:16]) &&
           (m_f >= ac[4]) && (m_f <= ac[5]);
      e_hs = (m_h < ac[0][15:0]);
      e_vs = (m_f < ac[2]);
      e_de = de;
      e_fe = ac[6][31] && (m_f == ac[7]);
      e_px = !de ? '0 : (pix_valid_i ? pix_data_i : ac[8][PW-1:0]);
      if (de && !pix_valid_i) e_st = 1;
      else if (cfg_we && cfg_addr == 4'd9 && cfg_wdata[0]) e_st = 0;
      if (m_f == fl - 1) begin
        m_f = 0; m_h = 0;
        for (int i = 0; i < 9; i++) ac[i] = sh[i];
      end else begin
        m_f++;
        m_h = (m_h == lp - 1) ? 0 : m_h + 1;
      end
      if (cfg_we && cfg_addr <= 4'd8) sh[cfg_addr] = cfg_wdata;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  // compare on every falling edge, half a clock after the edge that made the value
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R3 hsync", 32'(hsync_o), 32'(e_hs));
      chk("R4 vsync", 32'(vsync_o), 32'(e_vs));
      chk("R5 de", 32'(de_o), 32'(e_de));
      chk("R6 fetch", 32'(fetch_start_o), 32'(e_fe));
      chk("R7 pixel", 32'(pixel_o), 32'(e_px));
      chk("R8 underflow", 32'(underflow_o), 32'(e_st));
    end
  end

  // upstream pixel source
  always @(negedge clk) begin
    pix_data_i <= PW'(cyc * 37 + 5);
    pix_valid_i <= !(drop_mode && (cyc % 7 == 3));
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state on the outputs
    chk("R1 reset hsync", 32'(hsync_o), 0);
    chk("R1 reset de", 32'(de_o), 0);
    chk("R1 reset pixel", 32'(pixel_o), 0);
    chk("R1 reset underflow", 32'(underflow_o), 0);
    rst = 1'b0;
    // R2 R10: default raster, several frames
    run(130);
    // R7 R8: underruns fill with colour 0
    drop_mode = 1'b1;
    run(120);
    drop_mode = 1'b0;
    // R9: new timing written mid-frame, applied at the next wrap
    wr(4'd8, 32'h00ABCDEF);
    wr(4'd0, {16'd12, 16'd3});
    wr(4'd1, 32'd72);
    wr(4'd2, 32'd24);
    wr(4'd3, {16'd9, 16'd2});
    wr(4'd4, 32'd26);
    wr(4'd5, 32'd59);
    wr(4'd7, 32'd5);
    wr(4'd6, 32'h8000_0000);
    run(90);
    drop_mode = 1'b1;
    run(200);
    drop_mode = 1'b0;
    run(4);
    // R8: clear by write-one
    wr(4'd9, 32'd1);
    chk("R8 cleared", 32'(underflow_o), 0);
    run(100);
    chk("R8 stays clear", 32'(underflow_o), 0);
    // R8: clearing writes while underruns keep arriving
    drop_mode = 1'b1;
    for (int k = 0; k < 20; k++) wr(4'd9, 32'd1);
    drop_mode = 1'b0;
    // R5 R6: single-pixel window, window ends on last count, fetch on last count
    wr(4'd0, {16'd8, 16'd1});
    wr(4'd1, 32'd32);
    wr(4'd2, 32'd8);
    wr(4'd3, {16'd4, 16'd4});
    wr(4'd4, 32'd8);
    wr(4'd5, 32'd31);
    wr(4'd7, 32'd31);
    run(250);
    // R6: fetch at count 0 and then disabled
    wr(4'd7, 32'd0);
    run(100);
    wr(4'd6, 32'd0);
    run(100);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule